// File: doc/BRIEF.md
# Ring-organised operand store

This block holds six wide field words, 163 bits each by default, for a compact curve-arithmetic datapath. The words sit in a one-way ring instead of a random-access array. Slot 0 is the only slot with a data multiplexer. Every other slot is written only from its upstream neighbour. A sequencer reorders the words with five single-cycle commands:

- rotate the ring by one place;
- swap slots 0 and 1;
- duplicate slot 1 into slot 0;
- load a hard-wired curve constant into slot 0;
- write an arithmetic result into slot 0.

Slot 0 is exposed as the accumulator. Slots 1 and 2 are exposed as the first and second operands. A longer reordering, such as four rotations, is issued as the same command on consecutive cycles.

Top module: `ring_regfile`

## Requirements
- R1: After reset, all six slots hold zero, so the accumulator and both operand outputs read zero.
- R2: Opcode 3'd0 (idle), and every unused opcode 3'd6 and 3'd7, leaves all six slots unchanged.
- R3: Opcode 3'd1 (rotate) makes slot k+1 take the old slot k for k = 0..4, and slot 0 take the old slot 5, at the next rising edge.
- R4: Opcode 3'd2 (swap) exchanges slots 0 and 1 in one edge and leaves slots 2..5 unchanged.
- R5: Opcode 3'd3 (duplicate) writes the old slot 1 into slot 0 and leaves slots 1..5 unchanged.
- R6: Opcode 3'd4 (constant) writes into slot 0 the constant chosen by `const_sel`: 2'd0 gives `CONST_X`, 2'd1 gives `CONST_B`, 2'd2 gives `CONST_C`, and 2'd3 gives zero. Slots 1..5 are left unchanged.
- R7: Opcode 3'd5 (result write) writes `alu_res` into slot 0 and leaves slots 1..5 unchanged.
- R8: Six consecutive rotates return every slot to its starting content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Command opcode |
| const_sel | input | 2 | Constant selector for the constant command |
| alu_res | input | W | Arithmetic result for the result-write command |
| acc | output | W | Slot 0 |
| opnd_a | output | W | Slot 1 |
| opnd_b | output | W | Slot 2 |

## Verification
The bench fills the ring with distinct words and tracks a model of all six slots. It reaches the hidden slots 3..5 by rotating them out to the outputs. A rotate with the wrong direction or wrap would scramble this order. A swap that is implemented as a one-way copy would lose the accumulator word. The bench also checks that idle and unused opcodes leave the hidden slots intact, and that the selector code 3 loads zero rather than a stale constant.

// File: rtl/ring_regfile.sv
module ring_regfile #(
  parameter int W = 163,
  parameter int N = 6,
  parameter logic [W-1:0] CONST_X = {{(W-32){1'b0}}, 32'h1234_5678},
  parameter logic [W-1:0] CONST_B = {{(W-32){1'b0}}, 32'h0BAD_F00D},
  parameter logic [W-1:0] CONST_C = {{(W-32){1'b0}}, 32'h0C0F_FEE5}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op,
  input  logic [1:0]   const_sel,
  input  logic [W-1:0] alu_res,
  output logic [W-1:0] acc,
  output logic [W-1:0] opnd_a,
  output logic [W-1:0] opnd_b
);
  localparam logic [2:0] OP_ROT = 3'd1, OP_SWP = 3'd2, OP_DUP = 3'd3,
                         OP_CON = 3'd4, OP_RES = 3'd5;

  logic [W-1:0] slot [N];
  logic [W-1:0] konst, head_d;
  logic         rot, head_en;

  assign rot = (op == OP_ROT);

  always_comb
    case (const_sel)
      2'd0:    konst = CONST_X;
      2'd1:    konst = CONST_B;
      2'd2:    konst = CONST_C;
      default: konst = '0;
    endcase

  always_comb begin
    head_en = 1'b1;
    case (op)
      OP_ROT:  head_d = slot[N-1];
      OP_SWP,
      OP_DUP:  head_d = slot[1];
      OP_CON:  head_d = konst;
      OP_RES:  head_d = alu_res;
      default: begin head_d = slot[0]; head_en = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) slot[0] <= '0;
    else if (head_en) slot[0] <= head_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) slot[1] <= '0;
    else if (rot || op == OP_SWP) slot[1] <= slot[0];

  genvar k;
  generate
    for (k = 2; k < N; k++) begin : g_ring
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) slot[k] <= '0;
        else if (rot) slot[k] <= slot[k-1];
    end
  endgenerate

  assign acc    = slot[0];
  assign opnd_a = slot[1];
  assign opnd_b = slot[2];
endmodule

// File: rtl/ring_regfile_chk.sv
module ring_regfile_chk #(parameter int W = 163) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   op,
  input logic [W-1:0] alu_res,
  input logic [W-1:0] acc,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b
);
  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0; else live <= 1'b1;

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && (op == 3'd0 || op > 3'd5)) |=> $stable(acc) && $stable(opnd_a) && $stable(opnd_b));
  p_rot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && op == 3'd1) |=> opnd_a == $past(acc) && opnd_b == $past(opnd_a));
  p_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && op == 3'd2) |=> acc == $past(opnd_a) && opnd_a == $past(acc) && $stable(opnd_b));
  p_dup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && op == 3'd3) |=> acc == $past(opnd_a) && $stable(opnd_a) && $stable(opnd_b));
  p_const_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && op == 3'd4) |=> $stable(opnd_a) && $stable(opnd_b));
  p_res_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && op == 3'd5) |=> acc == $past(alu_res) && $stable(opnd_a) && $stable(opnd_b));
endmodule

bind ring_regfile ring_regfile_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .alu_res(alu_res),
  .acc(acc), .opnd_a(opnd_a), .opnd_b(opnd_b));

// File: tb/sim_ring_regfile.sv
module sim_ring_regfile;
  localparam int W = 163;
  localparam logic [W-1:0] KX = {{(W-32){1'b0}}, 32'h1234_5678};
  localparam logic [W-1:0] KB = {{(W-32){1'b0}}, 32'h0BAD_F00D};
  localparam logic [W-1:0] KC = {{(W-32){1'b0}}, 32'h0C0F_FEE5};

  logic clk = 0, rst_n = 0;
  logic [2:0] op = 0;
  logic [1:0] const_sel = 0;
  logic [W-1:0] alu_res = '0;
  logic [W-1:0] acc, opnd_a, opnd_b;
  logic [W-1:0] m [6];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ring_regfile u0 (.clk(clk), .rst_n(rst_n), .op(op), .const_sel(const_sel),
    .alu_res(alu_res), .acc(acc), .opnd_a(opnd_a), .opnd_b(opnd_b));

  function automatic logic [W-1:0] pat(int i);
    return {3'b101, {5{32'hA5000000 + i[31:0]}}};
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cmd(logic [2:0] o, logic [1:0] s = 0, logic [W-1:0] r = '0);
    logic [W-1:0] t;
    op = o; const_sel = s; alu_res = r;
    @(posedge clk); #1;
    op = 0;
    case (o)
      3'd1: begin t = m[5]; for (int k = 5; k > 0; k--) m[k] = m[k-1]; m[0] = t; end
      3'd2: begin t = m[0]; m[0] = m[1]; m[1] = t; end
      3'd3: m[0] = m[1];
      3'd4: m[0] = (s == 0) ? KX : (s == 1) ? KB : (s == 2) ? KC : '0;
      3'd5: m[0] = r;
      default: ;
    endcase
  endtask

  task automatic see(string req);
    chk(req, acc, m[0]); chk(req, opnd_a, m[1]); chk(req, opnd_b, m[2]);
  endtask

  task automatic see_all(string req);
    for (int k = 0; k < 6; k++) begin
      chk(req, acc, m[0]); cmd(3'd1);
    end
    see(req);
  endtask

  task automatic fill();
    for (int i = 0; i < 6; i++) begin cmd(3'd5, 0, pat(i)); cmd(3'd1); end
  endtask

  task automatic t_reset_r1();
    for (int k = 0; k < 6; k++) m[k] = '0;
    see("R1");
  endtask

  task automatic t_rotate_r3();
    fill(); cmd(3'd1); see("R3"); see_all("R3");
  endtask

  task automatic t_full_turn_r8();
    logic [W-1:0] a0, a1, a2;
    a0 = acc; a1 = opnd_a; a2 = opnd_b;
    for (int k = 0; k < 6; k++) cmd(3'd1);
    chk("R8", acc, a0); chk("R8", opnd_a, a1); chk("R8", opnd_b, a2);
  endtask

  task automatic t_swap_r4();
    cmd(3'd2); see("R4"); see_all("R4");
  endtask

  task automatic t_dup_r5();
    cmd(3'd3); see("R5"); see_all("R5");
  endtask

  task automatic t_const_r6();
    for (int s = 0; s < 4; s++) begin cmd(3'd4, s[1:0]); see("R6"); end
    cmd(3'd4, 2'd1); cmd(3'd4, 2'd3); chk("R6", acc, '0);
    see_all("R6");
  endtask

  task automatic t_res_r7();
    cmd(3'd5, 0, {W{1'b1}}); see("R7"); see_all("R7");
  endtask

  task automatic t_idle_r2();
    cmd(3'd0); cmd(3'd6, 2'd2, pat(9)); cmd(3'd7, 2'd0, pat(8));
    see("R2"); see_all("R2");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset_r1();
    rst_n = 1;
    @(posedge clk); #1;
    t_rotate_r3();
    t_full_turn_r8();
    t_swap_r4();
    t_dup_r5();
    t_const_r6();
    t_res_r7();
    t_idle_r2();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); checks++; fails++; $display("FAIL watchdog act=hung exp=done"); end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule